// File: doc/BRIEF.md
# PC Bus SRAM Expansion Select and Remap Logic

This block is the decode logic of an 8-bit PC bus memory card carrying a single 512 KB asynchronous SRAM. Six of the SRAM's eight 64 KB banks backfill conventional memory between the 256 KB mark and the 640 KB ceiling. The other two banks appear as upper-memory windows. One window can only sit in the E segment. The other is placed by jumpers in the A, B or D segment. The block turns the 20-bit bus address and the active-low bus commands into SRAM strobes and a 19-bit SRAM address. It also drives the direction and enable of the card's data buffer.

The memory decode never looks at the DMA address-enable line, so the card still takes part in DMA transfers. In those transfers an I/O command and a memory command run in the same cycle. Refresh dummy cycles, flagged by DMA acknowledge 0, are ignored. A parameter chooses how the chip enable is built. It can be qualified by a memory command, or it can follow the address decode alone. The second choice gives write cycles that are controlled by write enable.

Top module: `isa_ram_decoder`

## Requirements
- R1: A memory access to bus 0x40000–0x9FFFF selects the card. The SRAM address is then the bus address minus 0x40000. Bits 15:0 pass through, and bits 18:16 equal the bus segment (bits 19:16) minus 4.
- R2: Bus segments 0x0–0x3, 0xC and 0xF never select the card. Neither do segments A, B, D and E unless their window is enabled.
- R3: With `e_win_en` high, segment 0xE selects the card. The SRAM address is then 0x60000 plus bus bits 15:0.
- R4: With `x_win_en` high, the second window sits in the segment chosen by the jumpers `pick_a` (0xA), `pick_b` (0xB) and `pick_d` (0xD). If several are set, the lowest letter wins. The window maps to SRAM 0x70000 plus bus bits 15:0. With no jumper set, the window is absent.
- R5: With `card_off` high, the chip enable, output enable and write enable all stay high.
- R6: In the default mode, the chip enable, output enable, write enable and the memory part of the buffer enable assert only while `memr_n` or `memw_n` is low. An I/O command alone never selects the card.
- R7: While `dack0_n` is low, the chip enable, output enable and write enable all stay high.
- R8: While the card is selected, the output enable follows `memr_n` and the write enable follows `memw_n`. If both commands are low together, neither strobe asserts.
- R9: `buf_to_bus` is 1 (card drives the bus) while `memr_n` or `ior_n` is low, and 0 (pointing into the card) otherwise.
- R10: `buf_en_n` is low exactly when the memory is selected or `dev_sel_n` is low.
- R11: With the parameter CE_ADDR_ONLY = 1, the chip enable follows the address decode with no command present. The output enable and write enable stay command-qualified, so a write ends with `sram_we_n` high while `sram_ce_n` is still low.
- R12: A memory write with `ior_n` low in the same cycle, as in an I/O-to-memory DMA transfer, still asserts the chip enable and write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 20 | Bus address |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| ior_n | input | 1 | I/O read command, active low |
| dack0_n | input | 1 | DMA acknowledge 0 (refresh), active low |
| dev_sel_n | input | 1 | Select from the other on-card devices, active low |
| card_off | input | 1 | Global disable jumper, active high |
| e_win_en | input | 1 | E-segment window enable jumper |
| x_win_en | input | 1 | Second window enable jumper |
| pick_a | input | 1 | Place second window at segment A |
| pick_b | input | 1 | Place second window at segment B |
| pick_d | input | 1 | Place second window at segment D |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_addr | output | 19 | SRAM address |
| buf_to_bus | output | 1 | Data buffer direction, 1 = card to bus |
| buf_en_n | output | 1 | Data buffer enable, active low |

## Verification
The bench builds two copies of the block from the same stimulus. The first, `uut`, keeps the default command-qualified chip enable. It covers the remap of every region, the window priority, refresh and disable suppression, and the buffer rules. The second, `uut_ao`, sets CE_ADDR_ONLY = 1. This brings the address-only chip enable within reach. In that copy the chip enable is low with no command present and outlasts the write enable at the end of a write.

// File: rtl/isa_ram_decoder_pkg.sv
package isa_ram_decoder_pkg;
   localparam int SEG_W = 4;
   localparam logic [SEG_W-1:0] SEG_A = 4'hA;
   localparam logic [SEG_W-1:0] SEG_B = 4'hB;
   localparam logic [SEG_W-1:0] SEG_D = 4'hD;
   localparam logic [SEG_W-1:0] SEG_E = 4'hE;
   localparam int N_PICK = 3;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_CONV = 2'd1,
      RGN_EWIN = 2'd2,
      RGN_XWIN = 2'd3
   } region_t;

   function automatic logic [SEG_W-1:0] pick_seg(input int idx);
      case (idx)
         0: pick_seg = SEG_A;
         1: pick_seg = SEG_B;
         default: pick_seg = SEG_D;
      endcase
   endfunction
endpackage

// File: rtl/memdec_win_pick.sv
module memdec_win_pick
   import isa_ram_decoder_pkg::*;
(
   input  logic [N_PICK-1:0] picks,
   output logic [SEG_W-1:0]  win_seg,
   output logic              win_valid
);
   // candidates scanned from highest letter down so the lowest letter wins
   always_comb begin
      win_seg   = '0;
      win_valid = 1'b0;
      for (int i = N_PICK - 1; i >= 0; i--) begin
         if (picks[i]) begin
            win_seg   = pick_seg(i);
            win_valid = 1'b1;
         end
      end
   end
endmodule

// File: rtl/memdec_region.sv
module memdec_region
   import isa_ram_decoder_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int BLK_AW  = 16,
   parameter int SRAM_AW = 19,
   parameter int CONV_LO = 4,
   parameter int CONV_HI = 9
) (
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               card_off,
   input  logic               dack0_n,
   input  logic               e_win_en,
   input  logic               x_win_en,
   input  logic [SEG_W-1:0]   win_seg,
   input  logic               win_valid,
   output logic               hit,
   output logic [SRAM_AW-1:0] sram_addr
);
   localparam int UW = SRAM_AW - BLK_AW;
   localparam logic [UW-1:0] E_BANK = UW'((1 << UW) - 2);
   localparam logic [UW-1:0] X_BANK = UW'((1 << UW) - 1);
   localparam logic [SEG_W-1:0] LO_SEG = SEG_W'(CONV_LO);
   localparam logic [SEG_W-1:0] HI_SEG = SEG_W'(CONV_HI);

   logic [SEG_W-1:0] seg;
   logic [BLK_AW-1:0] low;
   region_t rgn;
   logic [UW-1:0] bank;
   logic [SEG_W-1:0] conv_ofs;

   assign seg      = bus_addr[ADDR_W-1 -: SEG_W];
   assign low      = bus_addr[BLK_AW-1:0];
   assign conv_ofs = seg - LO_SEG;

   always_comb begin
      rgn = RGN_NONE;
      if (seg >= LO_SEG && seg <= HI_SEG)             rgn = RGN_CONV;
      else if (e_win_en && seg == SEG_E)              rgn = RGN_EWIN;
      else if (x_win_en && win_valid && seg == win_seg) rgn = RGN_XWIN;
   end

   always_comb begin
      case (rgn)
         RGN_CONV: bank = conv_ofs[UW-1:0];
         RGN_EWIN: bank = E_BANK;
         RGN_XWIN: bank = X_BANK;
         default:  bank = '0;
      endcase
   end

   assign hit       = (rgn != RGN_NONE) && !card_off && dack0_n;
   assign sram_addr = {bank, low};
endmodule

// File: rtl/memdec_strobes.sv
module memdec_strobes #(
   parameter bit CE_ADDR_ONLY = 1'b0
) (
   input  logic hit,
   input  logic memr_n,
   input  logic memw_n,
   input  logic ior_n,
   input  logic dev_sel_n,
   output logic sram_ce_n,
   output logic sram_oe_n,
   output logic sram_we_n,
   output logic buf_to_bus,
   output logic buf_en_n
);
   logic rd, wr, mem_sel;

   assign rd      = !memr_n && memw_n;
   assign wr      = !memw_n && memr_n;
   assign mem_sel = hit && (!memr_n || !memw_n);

   generate
      if (CE_ADDR_ONLY) begin : g_ce_addr
         assign sram_ce_n = !hit;
      end else begin : g_ce_cmd
         assign sram_ce_n = !mem_sel;
      end
   endgenerate

   assign sram_oe_n  = !(mem_sel && rd);
   assign sram_we_n  = !(mem_sel && wr);
   assign buf_to_bus = !memr_n || !ior_n;
   assign buf_en_n   = !(mem_sel || !dev_sel_n);
endmodule

// File: rtl/isa_ram_decoder.sv
module isa_ram_decoder
   import isa_ram_decoder_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int BLK_AW       = 16,
   parameter int SRAM_AW      = 19,
   parameter int CONV_LO      = 4,
   parameter int CONV_HI      = 9,
   parameter bit CE_ADDR_ONLY = 1'b0
) (
   input  logic               [ADDR_W-1:0] bus_addr,
   input  logic                            memr_n,
   input  logic                            memw_n,
   input  logic                            ior_n,
   input  logic                            dack0_n,
   input  logic                            dev_sel_n,
   input  logic                            card_off,
   input  logic                            e_win_en,
   input  logic                            x_win_en,
   input  logic                            pick_a,
   input  logic                            pick_b,
   input  logic                            pick_d,
   output logic                            sram_ce_n,
   output logic                            sram_oe_n,
   output logic                            sram_we_n,
   output logic              [SRAM_AW-1:0] sram_addr,
   output logic                            buf_to_bus,
   output logic                            buf_en_n
);
   localparam int UW = SRAM_AW - BLK_AW;

   generate
      if (ADDR_W - BLK_AW != SEG_W) begin : g_bad_seg
         $error("segment field must be %0d bits", SEG_W);
      end
      if (UW < 2) begin : g_bad_sram
         $error("SRAM must hold at least four banks");
      end
      if (CONV_HI < CONV_LO || CONV_HI - CONV_LO + 1 > (1 << UW) - 2) begin : g_bad_conv
         $error("conventional range does not fit below the two windows");
      end
   endgenerate

   logic [SEG_W-1:0] win_seg;
   logic win_valid, hit;

   memdec_win_pick u_pick (
      .picks     ({pick_d, pick_b, pick_a}),
      .win_seg   (win_seg),
      .win_valid (win_valid)
   );

   memdec_region #(
      .ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .SRAM_AW(SRAM_AW),
      .CONV_LO(CONV_LO), .CONV_HI(CONV_HI)
   ) u_region (
      .bus_addr  (bus_addr),
      .card_off  (card_off),
      .dack0_n   (dack0_n),
      .e_win_en  (e_win_en),
      .x_win_en  (x_win_en),
      .win_seg   (win_seg),
      .win_valid (win_valid),
      .hit       (hit),
      .sram_addr (sram_addr)
   );

   memdec_strobes #(.CE_ADDR_ONLY(CE_ADDR_ONLY)) u_strobes (
      .hit        (hit),
      .memr_n     (memr_n),
      .memw_n     (memw_n),
      .ior_n      (ior_n),
      .dev_sel_n  (dev_sel_n),
      .sram_ce_n  (sram_ce_n),
      .sram_oe_n  (sram_oe_n),
      .sram_we_n  (sram_we_n),
      .buf_to_bus (buf_to_bus),
      .buf_en_n   (buf_en_n)
   );
endmodule

// File: rtl/isa_ram_decoder_chk.sv
module isa_ram_decoder_chk #(
   parameter bit CE_ADDR_ONLY = 1'b0
) (
   input logic memr_n,
   input logic memw_n,
   input logic ior_n,
   input logic dack0_n,
   input logic card_off,
   input logic sram_ce_n,
   input logic sram_oe_n,
   input logic sram_we_n,
   input logic buf_to_bus
);
   logic known;
   assign known = !$isunknown({memr_n, memw_n, ior_n, dack0_n, card_off,
                               sram_ce_n, sram_oe_n, sram_we_n, buf_to_bus});

   always_comb begin
      if (known) begin
         // R8: output and write enables never together
         p_oe_we_excl_r8: assert (sram_oe_n || sram_we_n);
         // R7: refresh cycles leave the SRAM idle
         p_refresh_quiet_r7: assert (dack0_n || (sram_ce_n && sram_oe_n && sram_we_n));
         // R5: global disable leaves the SRAM idle
         p_card_off_r5: assert (!card_off || (sram_ce_n && sram_oe_n && sram_we_n));
         // R9: with no read command the buffer points into the card
         p_buf_inward_r9: assert (!memr_n || !ior_n || !buf_to_bus);
         // R6: without a memory command no strobe asserts
         p_no_cmd_r6: assert (!(memr_n && memw_n) || (sram_oe_n && sram_we_n &&
                               (CE_ADDR_ONLY || sram_ce_n)));
         // R11: any write or read strobe implies chip enable
         p_strobe_needs_ce_r11: assert (!sram_ce_n || (sram_oe_n && sram_we_n));
      end
   end
endmodule

bind isa_ram_decoder isa_ram_decoder_chk #(.CE_ADDR_ONLY(CE_ADDR_ONLY)) u_chk (
   .memr_n     (memr_n),
   .memw_n     (memw_n),
   .ior_n      (ior_n),
   .dack0_n    (dack0_n),
   .card_off   (card_off),
   .sram_ce_n  (sram_ce_n),
   .sram_oe_n  (sram_oe_n),
   .sram_we_n  (sram_we_n),
   .buf_to_bus (buf_to_bus)
);

// File: tb/isa_ram_decoder_test.sv
module isa_ram_decoder_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [19:0] bus_addr;
   logic memr_n, memw_n, ior_n, dack0_n, dev_sel_n;
   logic card_off, e_win_en, x_win_en, pick_a, pick_b, pick_d;
   logic ce_n, oe_n, we_n, to_bus, en_n;
   logic [18:0] sa;
   logic ce2_n, oe2_n, we2_n, to_bus2, en2_n;
   logic [18:0] sa2;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   isa_ram_decoder uut (
      .bus_addr(bus_addr), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
      .dack0_n(dack0_n), .dev_sel_n(dev_sel_n), .card_off(card_off),
      .e_win_en(e_win_en), .x_win_en(x_win_en), .pick_a(pick_a),
      .pick_b(pick_b), .pick_d(pick_d), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
      .sram_we_n(we_n), .sram_addr(sa), .buf_to_bus(to_bus), .buf_en_n(en_n));

   isa_ram_decoder #(.CE_ADDR_ONLY(1'b1)) uut_ao (
      .bus_addr(bus_addr), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
      .dack0_n(dack0_n), .dev_sel_n(dev_sel_n), .card_off(card_off),
      .e_win_en(e_win_en), .x_win_en(x_win_en), .pick_a(pick_a),
      .pick_b(pick_b), .pick_d(pick_d), .sram_ce_n(ce2_n), .sram_oe_n(oe2_n),
      .sram_we_n(we2_n), .sram_addr(sa2), .buf_to_bus(to_bus2), .buf_en_n(en2_n));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // drive the bus, then let the combinational outputs settle
   task automatic bus(input logic [19:0] a, input logic r, input logic w,
                      input logic io, input logic dk);
      bus_addr = a; memr_n = r; memw_n = w; ior_n = io; dack0_n = dk;
      #2;
   endtask

   task automatic jumpers(input logic off, input logic e, input logic x,
                          input logic a, input logic b, input logic d);
      card_off = off; e_win_en = e; x_win_en = x; pick_a = a; pick_b = b; pick_d = d;
   endtask

   task automatic t_idle;
      jumpers(0, 1, 1, 1, 0, 0); dev_sel_n = 1;
      bus(20'h50000, 1, 1, 1, 1);
      chk("R6", "idle ce", ce_n, 1);
      chk("R6", "idle oe", oe_n, 1);
      chk("R6", "idle we", we_n, 1);
      chk("R10", "idle buf en", en_n, 1);
      chk("R9", "idle dir", to_bus, 0);
   endtask

   task automatic t_conv;
      logic [19:0] list [4] = '{20'h40000, 20'h5ABCD, 20'h80012, 20'h9FFFF};
      foreach (list[i]) begin
         bus(list[i], 0, 1, 1, 1);
         chk("R1", "conv ce", ce_n, 0);
         chk("R1", "conv oe", oe_n, 0);
         chk("R1", "conv addr", sa, int'(19'(list[i] - 20'h40000)));
      end
      bus(20'h61234, 1, 0, 1, 1);
      chk("R1", "conv write we", we_n, 0);
      chk("R8", "conv write oe", oe_n, 1);
   endtask

   task automatic t_unmapped;
      logic [19:0] list [4] = '{20'h00000, 20'h3FFFF, 20'hC8000, 20'hF0000};
      foreach (list[i]) begin
         bus(list[i], 0, 1, 1, 1);
         chk("R2", "unmapped ce", ce_n, 1);
         chk("R2", "unmapped buf en", en_n, 1);
      end
      jumpers(0, 0, 0, 1, 0, 0);
      bus(20'hE0100, 0, 1, 1, 1);
      chk("R2", "E window off", ce_n, 1);
      bus(20'hA0100, 0, 1, 1, 1);
      chk("R2", "second window off", ce_n, 1);
      jumpers(0, 1, 1, 1, 0, 0);
   endtask

   task automatic t_ewin;
      bus(20'hE0000, 0, 1, 1, 1);
      chk("R3", "E ce", ce_n, 0);
      chk("R3", "E addr lo", sa, 19'h60000);
      bus(20'hEFFFF, 1, 0, 1, 1);
      chk("R3", "E addr hi", sa, 19'h6FFFF);
      chk("R3", "E we", we_n, 0);
   endtask

   task automatic t_xwin;
      jumpers(0, 1, 1, 0, 1, 0);
      bus(20'hB1234, 0, 1, 1, 1);
      chk("R4", "B ce", ce_n, 0);
      chk("R4", "B addr", sa, 19'h71234);
      bus(20'hA1234, 0, 1, 1, 1);
      chk("R4", "A unpicked", ce_n, 1);
      jumpers(0, 1, 1, 0, 0, 1);
      bus(20'hDFFFF, 0, 1, 1, 1);
      chk("R4", "D ce", ce_n, 0);
      chk("R4", "D addr", sa, 19'h7FFFF);
      jumpers(0, 1, 1, 1, 0, 1);
      bus(20'hD0000, 0, 1, 1, 1);
      chk("R4", "A beats D, D off", ce_n, 1);
      bus(20'hA0040, 0, 1, 1, 1);
      chk("R4", "A beats D, A on", ce_n, 0);
      chk("R4", "A addr", sa, 19'h70040);
      jumpers(0, 1, 1, 0, 1, 1);
      bus(20'hD0000, 0, 1, 1, 1);
      chk("R4", "B beats D", ce_n, 1);
      jumpers(0, 1, 1, 0, 0, 0);
      bus(20'hA0000, 0, 1, 1, 1);
      chk("R4", "no pick A", ce_n, 1);
      bus(20'hD0000, 0, 1, 1, 1);
      chk("R4", "no pick D", ce_n, 1);
      jumpers(0, 1, 1, 1, 0, 0);
   endtask

   task automatic t_disable;
      jumpers(1, 1, 1, 1, 0, 0);
      bus(20'h70000, 1, 0, 1, 1);
      chk("R5", "off ce", ce_n, 1);
      chk("R5", "off we", we_n, 1);
      chk("R5", "off ce addr-only", ce2_n, 1);
      dev_sel_n = 0; #2;
      chk("R10", "off dev sel buf en", en_n, 0);
      dev_sel_n = 1;
      jumpers(0, 1, 1, 1, 0, 0);
   endtask

   task automatic t_refresh;
      bus(20'h40020, 0, 1, 1, 0);
      chk("R7", "refresh ce", ce_n, 1);
      chk("R7", "refresh oe", oe_n, 1);
      chk("R7", "refresh ce addr-only", ce2_n, 1);
      chk("R7", "refresh buf en", en_n, 1);
   endtask

   task automatic t_io_only;
      bus(20'h503F0, 1, 1, 0, 1);
      chk("R6", "io ce", ce_n, 1);
      chk("R6", "io buf en", en_n, 1);
      chk("R9", "io dir", to_bus, 1);
   endtask

   task automatic t_both_cmds;
      bus(20'h50000, 0, 0, 1, 1);
      chk("R8", "both oe", oe_n, 1);
      chk("R8", "both we", we_n, 1);
   endtask

   task automatic t_buffer;
      bus(20'h50000, 0, 1, 1, 1);
      chk("R10", "read buf en", en_n, 0);
      chk("R9", "read dir", to_bus, 1);
      bus(20'h50000, 1, 0, 1, 1);
      chk("R10", "write buf en", en_n, 0);
      chk("R9", "write dir", to_bus, 0);
      bus(20'h20000, 1, 0, 1, 1);
      dev_sel_n = 0; #2;
      chk("R10", "dev sel buf en", en_n, 0);
      dev_sel_n = 1; #2;
      chk("R10", "no sel buf en", en_n, 1);
   endtask

   task automatic t_dma;
      bus(20'h9ABCD, 1, 0, 0, 1);
      chk("R12", "dma ce", ce_n, 0);
      chk("R12", "dma we", we_n, 0);
      chk("R12", "dma addr", sa, 19'h5ABCD);
   endtask

   task automatic t_addr_only;
      bus(20'h48000, 1, 1, 1, 1);
      chk("R11", "ao ce no cmd", ce2_n, 0);
      chk("R11", "ao oe no cmd", oe2_n, 1);
      chk("R11", "ao we no cmd", we2_n, 1);
      chk("R11", "ao buf en no cmd", en2_n, 1);
      bus(20'h48000, 1, 0, 1, 1);
      chk("R11", "ao write we", we2_n, 0);
      bus(20'h48000, 1, 1, 1, 1);
      chk("R11", "ao write end we", we2_n, 1);
      chk("R11", "ao write end ce", ce2_n, 0);
      bus(20'h30000, 1, 1, 1, 1);
      chk("R11", "ao unmapped ce", ce2_n, 1);
   endtask

   initial begin
      t_idle;
      t_conv;
      t_unmapped;
      t_ewin;
      t_xwin;
      t_disable;
      t_refresh;
      t_io_only;
      t_both_cmds;
      t_buffer;
      t_dma;
      t_addr_only;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule